// File: doc/BRIEF.md
# Load/Store Address Generator

This block computes the memory address for a single-register load or store. On each accepted request it takes a 32-bit base register value, the current program counter, a 12-bit unsigned immediate offset with an add/subtract control, a transfer-size bit and an addressing-mode code. It returns the effective address, the transfer size, and a new value for the base register together with a write-enable for that value.

Five addressing modes are supported. Register-indirect uses the base alone. Pre-indexed adds the offset before the access. Pre-indexed with writeback does the same and also updates the base. Post-indexed accesses at the plain base and updates it afterwards. Program-counter-relative forms its address from the program counter plus a fixed pipeline bias of 8. All results are registered, so they appear one clock after the request, marked by an output valid strobe. The surrounding pipeline performs the memory access and the register-file write.

Top module: `ls_agu_top`

## Requirements
- R1: While reset is asserted and after its release with no request, `out_valid` and `out_wb_en` are 0.
- R2: A request presented with `req_valid`=1 at a rising edge produces `out_valid`=1 together with all of its results after that edge, for exactly one cycle per request; `req_valid`=0 at an edge gives `out_valid`=0 after it.
- R3: Mode code 0 (register-indirect): `out_addr` equals the base, `out_wb_en`=0.
- R4: Mode code 1 (pre-indexed): `out_addr` is the base with the offset applied, `out_wb_en`=0, and `out_wb_data` carries the unchanged base.
- R5: Mode code 2 (pre-indexed with writeback): `out_addr` is the base with the offset applied, `out_wb_en`=1, and `out_wb_data` equals `out_addr`.
- R6: Mode code 3 (post-indexed): `out_addr` equals the unmodified base, `out_wb_en`=1, and `out_wb_data` is the base with the offset applied.
- R7: Mode code 4 (PC-relative): `out_addr` is the program counter plus 8 with the offset applied, `out_wb_en`=0.
- R8: The offset is a 12-bit unsigned value, zero-extended; `req_sub`=0 adds it and `req_sub`=1 subtracts it, in every mode that uses it.
- R9: All address and writeback sums wrap modulo 2^32.
- R10: `out_byte` repeats `req_byte` of the request (1 = 8-bit byte transfer, 0 = 32-bit word transfer).
- R11: Mode codes 5, 6 and 7 behave exactly like code 0.
- R12: `out_wb_en` is never 1 while `out_valid` is 0; for modes without writeback `out_wb_data` carries the base unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| req_mode | input | 3 | Addressing-mode code (0..4 defined, 5..7 as 0) |
| req_base | input | 32 | Base register value |
| req_pc | input | 32 | Program counter of the instruction |
| req_offset | input | 12 | Unsigned immediate offset |
| req_sub | input | 1 | 1 subtracts the offset, 0 adds it |
| req_byte | input | 1 | 1 byte transfer, 0 word transfer |
| out_valid | output | 1 | Results valid this cycle |
| out_addr | output | 32 | Effective address |
| out_byte | output | 1 | Transfer size of the result |
| out_wb_en | output | 1 | Base register write enable |
| out_wb_data | output | 32 | New base register value |

## Verification
Every result of this block is due exactly one rising edge after the request that caused it: address, size, writeback enable and writeback value all come out of the same register stage together with `out_valid`. The bench drives a request just after a falling edge, lets one rising edge capture it, and compares all outputs at the following falling edge against a model that computed the expectation when the request was driven. Idle cycles between requests are compared too, so a stray valid or writeback enable is seen in the cycle it occurs.

// File: rtl/ls_agu_pkg.sv
package ls_agu_pkg;

  // Addressing-mode codes; codes 5..7 fall back to register-indirect.
  typedef enum logic [2:0] {
    AGU_INDIRECT = 3'd0,
    AGU_PRE      = 3'd1,
    AGU_PRE_WB   = 3'd2,
    AGU_POST     = 3'd3,
    AGU_PCREL    = 3'd4
  } agu_mode_e;

  // Decoded steering for one request.
  typedef struct packed {
    logic addr_from_pc;   // address comes from the biased program counter path
    logic addr_with_off;  // address comes from base + offset
    logic writeback;      // base register gets base + offset
  } agu_ctrl_t;

endpackage

// File: rtl/agu_mode_decode.sv
module agu_mode_decode
  import ls_agu_pkg::*;
(
  input  logic [2:0] mode,
  output agu_ctrl_t  ctrl
);

  always_comb begin
    ctrl = '0;
    case (mode)
      AGU_PRE:    ctrl.addr_with_off = 1'b1;
      AGU_PRE_WB: begin
        ctrl.addr_with_off = 1'b1;
        ctrl.writeback     = 1'b1;
      end
      AGU_POST:   ctrl.writeback     = 1'b1;
      AGU_PCREL:  ctrl.addr_from_pc  = 1'b1;
      default:    ctrl = '0;
    endcase
  end

endmodule

// File: rtl/agu_offset_adder.sv
module agu_offset_adder #(
  parameter int AW = 32,
  parameter int OW = 12
) (
  input  logic [AW-1:0] opnd,
  input  logic [OW-1:0] offset,
  input  logic          sub,
  output logic [AW-1:0] sum
);

  localparam int PAD = AW - OW;

  // Zero-extended immediate applied in either direction, modulo 2^AW.
  function automatic logic [AW-1:0] apply_off(input logic [AW-1:0] a,
                                              input logic [OW-1:0] o,
                                              input logic          s);
    logic [AW-1:0] ext;
    ext = {{PAD{1'b0}}, o};
    return s ? (a - ext) : (a + ext);
  endfunction

  assign sum = apply_off(opnd, offset, sub);

endmodule

// File: rtl/agu_out_stage.sv
module agu_out_stage #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [AW-1:0] in_addr,
  input  logic          in_byte,
  input  logic          in_wb_en,
  input  logic [AW-1:0] in_wb_data,
  output logic          q_valid,
  output logic [AW-1:0] q_addr,
  output logic          q_byte,
  output logic          q_wb_en,
  output logic [AW-1:0] q_wb_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid   <= 1'b0;
      q_wb_en   <= 1'b0;
      q_addr    <= '0;
      q_byte    <= 1'b0;
      q_wb_data <= '0;
    end else begin
      q_valid <= in_valid;
      q_wb_en <= in_valid & in_wb_en;
      if (in_valid) begin
        q_addr    <= in_addr;
        q_byte    <= in_byte;
        q_wb_data <= in_wb_data;
      end
    end
  end

endmodule

// File: rtl/ls_agu_top.sv
module ls_agu_top
  import ls_agu_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int OFF_W   = 12,
  parameter int PC_BIAS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_mode,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [ADDR_W-1:0] req_pc,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic              req_sub,
  input  logic              req_byte,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_byte,
  output logic              out_wb_en,
  output logic [ADDR_W-1:0] out_wb_data
);

  localparam int NPATH = 2;  // path 0: base register, path 1: biased PC

  // Program counter as seen by the instruction, ahead by the pipeline bias.
  function automatic logic [ADDR_W-1:0] bias_pc(input logic [ADDR_W-1:0] pc);
    return pc + ADDR_W'(PC_BIAS);
  endfunction

  agu_ctrl_t         ctrl;
  logic [ADDR_W-1:0] path_in  [NPATH];
  logic [ADDR_W-1:0] path_sum [NPATH];

  // Named internal events for the checker.
  logic [ADDR_W-1:0] sum_base;
  logic [ADDR_W-1:0] sum_pc;
  logic              ev_writeback;
  logic              ev_pc_path;
  logic [ADDR_W-1:0] nxt_addr;
  logic [ADDR_W-1:0] nxt_wb_data;

  agu_mode_decode u_dec (
    .mode (req_mode),
    .ctrl (ctrl)
  );

  assign path_in[0] = req_base;
  assign path_in[1] = bias_pc(req_pc);

  for (genvar g = 0; g < NPATH; g++) begin : g_path
    agu_offset_adder #(.AW(ADDR_W), .OW(OFF_W)) u_add (
      .opnd   (path_in[g]),
      .offset (req_offset),
      .sub    (req_sub),
      .sum    (path_sum[g])
    );
  end

  assign sum_base     = path_sum[0];
  assign sum_pc       = path_sum[1];
  assign ev_writeback = req_valid & ctrl.writeback;
  assign ev_pc_path   = req_valid & ctrl.addr_from_pc;

  always_comb begin
    if (ctrl.addr_from_pc)       nxt_addr = sum_pc;
    else if (ctrl.addr_with_off) nxt_addr = sum_base;
    else                         nxt_addr = req_base;
  end

  assign nxt_wb_data = ctrl.writeback ? sum_base : req_base;

  agu_out_stage #(.AW(ADDR_W)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (req_valid),
    .in_addr    (nxt_addr),
    .in_byte    (req_byte),
    .in_wb_en   (ctrl.writeback),
    .in_wb_data (nxt_wb_data),
    .q_valid    (out_valid),
    .q_addr     (out_addr),
    .q_byte     (out_byte),
    .q_wb_en    (out_wb_en),
    .q_wb_data  (out_wb_data)
  );

endmodule

// File: rtl/ls_agu_chk.sv
module ls_agu_chk
  import ls_agu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [2:0]        req_mode,
  input logic [ADDR_W-1:0] req_base,
  input logic              req_byte,
  input logic              ev_writeback,
  input logic              ev_pc_path,
  input logic              out_valid,
  input logic [ADDR_W-1:0] out_addr,
  input logic              out_byte,
  input logic              out_wb_en,
  input logic [ADDR_W-1:0] out_wb_data
);

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);

  // R2
  idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid);

  // R12
  wb_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_wb_en |-> out_valid);

  // R3
  indirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode == AGU_INDIRECT) |=>
      (out_addr == $past(req_base) && !out_wb_en));

  // R4
  pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode == AGU_PRE) |=>
      (!out_wb_en && out_wb_data == $past(req_base)));

  // R5
  prewb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode == AGU_PRE_WB) |=>
      (out_wb_en && out_wb_data == out_addr));

  // R6
  post_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode == AGU_POST) |=>
      (out_wb_en && out_addr == $past(req_base)));

  // R7
  pcrel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pc_path |=> !out_wb_en);

  // R12
  wb_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_writeback |=> out_wb_en);

  // R10
  size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (out_byte == $past(req_byte)));

  // R11
  spare_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode > 3'd4) |=>
      (out_addr == $past(req_base) && !out_wb_en));

endmodule

bind ls_agu_top ls_agu_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_mode     (req_mode),
  .req_base     (req_base),
  .req_byte     (req_byte),
  .ev_writeback (ev_writeback),
  .ev_pc_path   (ev_pc_path),
  .out_valid    (out_valid),
  .out_addr     (out_addr),
  .out_byte     (out_byte),
  .out_wb_en    (out_wb_en),
  .out_wb_data  (out_wb_data)
);

// File: tb/ls_agu_top_bench.sv
`timescale 1ns/1ps
module ls_agu_top_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_mode = 3'd0;
  logic [31:0] req_base = 32'd0;
  logic [31:0] req_pc = 32'd0;
  logic [11:0] req_offset = 12'd0;
  logic        req_sub = 1'b0;
  logic        req_byte = 1'b0;
  logic        out_valid;
  logic [31:0] out_addr;
  logic        out_byte;
  logic        out_wb_en;
  logic [31:0] out_wb_data;

  int checks = 0;
  int errors = 0;

  // Pending expectation for the next comparison
  logic        e_valid = 1'b0;
  logic [31:0] e_addr = 32'd0;
  logic        e_byte = 1'b0;
  logic        e_wb_en = 1'b0;
  logic [31:0] e_wb_data = 32'd0;
  string       e_tag = "R1";

  always #5 clk = ~clk;  // 100 MHz

  ls_agu_top u_ls_agu_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .req_base(req_base), .req_pc(req_pc), .req_offset(req_offset),
    .req_sub(req_sub), .req_byte(req_byte), .out_valid(out_valid),
    .out_addr(out_addr), .out_byte(out_byte), .out_wb_en(out_wb_en),
    .out_wb_data(out_wb_data)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Reference: offset applied with 64-bit integers, folded to 32 bits.
  function automatic logic [31:0] ref_move(input logic [31:0] a,
                                           input logic [11:0] o,
                                           input logic s);
    longint unsigned v;
    if (s) v = longint'(a) + 64'h1_0000_0000 - longint'(o);
    else   v = longint'(a) + longint'(o);
    return v[31:0];
  endfunction

  // Compare outputs for the previous cycle, then drive a new cycle.
  task automatic step(input string tag, input logic v, input logic [2:0] m,
                      input logic [31:0] b, input logic [31:0] pc,
                      input logic [11:0] o, input logic s, input logic by);
    @(negedge clk);
    chk(e_tag, "valid", {31'd0, out_valid}, {31'd0, e_valid});
    chk((e_valid ? e_tag : "R12"), "wb_en", {31'd0, out_wb_en}, {31'd0, e_wb_en});
    if (e_valid) begin
      chk(e_tag, "addr", out_addr, e_addr);
      chk("R10", "byte", {31'd0, out_byte}, {31'd0, e_byte});
      chk(e_tag, "wb_data", out_wb_data, e_wb_data);
    end
    req_valid = v; req_mode = m; req_base = b; req_pc = pc;
    req_offset = o; req_sub = s; req_byte = by;
    e_valid = v; e_tag = tag; e_byte = by;
    e_wb_en = 1'b0; e_addr = b; e_wb_data = b;
    if (v) begin
      if (m == 3'd1) e_addr = ref_move(b, o, s);
      else if (m == 3'd2) begin
        e_addr = ref_move(b, o, s); e_wb_data = e_addr; e_wb_en = 1'b1;
      end else if (m == 3'd3) begin
        e_wb_data = ref_move(b, o, s); e_wb_en = 1'b1;
      end else if (m == 3'd4) e_addr = ref_move(pc + 32'd8, o, s);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "valid in reset", {31'd0, out_valid}, 32'd0);
    chk("R1", "wb_en in reset", {31'd0, out_wb_en}, 32'd0);
    rst_n = 1'b1;
    step("R1", 0, 0, 32'h0, 32'h0, 12'h0, 0, 0);
    step("R1", 0, 0, 32'h0, 32'h0, 12'h0, 0, 0);
    // R3 indirect, word and byte
    step("R3", 1, 3'd0, 32'h0000_1000, 32'h8000, 12'h040, 0, 0);
    step("R3", 1, 3'd0, 32'hDEAD_BEEC, 32'h8000, 12'hFFF, 1, 1);
    // R4 pre-indexed, add and subtract (R8)
    step("R4", 1, 3'd1, 32'h0000_2000, 32'h8000, 12'h004, 0, 0);
    step("R8", 1, 3'd1, 32'h0000_2000, 32'h8000, 12'h010, 1, 1);
    // R5 pre-indexed with writeback
    step("R5", 1, 3'd2, 32'h0001_0000, 32'h8000, 12'h004, 0, 0);
    step("R5", 1, 3'd2, 32'h0001_0000, 32'h8000, 12'h800, 1, 0);
    // R6 post-indexed
    step("R6", 1, 3'd3, 32'h0000_3000, 32'h8000, 12'h004, 0, 1);
    step("R6", 1, 3'd3, 32'h0000_3000, 32'h8000, 12'h0FF, 1, 0);
    // R7 PC-relative
    step("R7", 1, 3'd4, 32'h1234_5678, 32'h0000_8000, 12'h088, 0, 0);
    step("R7", 1, 3'd4, 32'h1234_5678, 32'h0000_8004, 12'h010, 1, 1);
    // R12 idle gap after a writeback request
    step("R6", 1, 3'd3, 32'h0000_4000, 32'h0, 12'h008, 0, 0);
    step("R12", 0, 3'd2, 32'h0000_5000, 32'h0, 12'h008, 0, 0);
    step("R12", 0, 3'd3, 32'h0000_5000, 32'h0, 12'h008, 0, 0);
    // R9 wraparound
    step("R9", 1, 3'd2, 32'hFFFF_FFF0, 32'h0, 12'hFFF, 0, 0);
    step("R9", 1, 3'd3, 32'h0000_0005, 32'h0, 12'h00A, 1, 0);
    step("R9", 1, 3'd4, 32'h0, 32'hFFFF_FFFC, 12'h000, 0, 0);
    step("R9", 1, 3'd4, 32'h0, 32'h0000_0000, 12'h00C, 1, 1);
    // R11 spare codes act like indirect
    step("R11", 1, 3'd5, 32'hA000_0000, 32'h8000, 12'h123, 0, 0);
    step("R11", 1, 3'd6, 32'hA000_0004, 32'h8000, 12'h123, 1, 1);
    step("R11", 1, 3'd7, 32'hA000_0008, 32'h8000, 12'h123, 0, 0);
    // R2 back-to-back mix then idle
    for (int i = 0; i < 10; i++)
      step("R2", 1, 3'(i % 5), 32'h0000_1000 * i, 32'h100 * i,
           12'(i * 37), i[0], i[1]);
    step("R2", 0, 0, 32'h0, 32'h0, 12'h0, 0, 0);
    step("R2", 0, 0, 32'h0, 32'h0, 12'h0, 0, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule